// File: doc/BRIEF.md
# Ring-Oscillator Key Generator

This block builds a 64-bit device key on request from 64 pairs of free-running oscillator signals. Each key bit belongs to one cell with two oscillator inputs. The bit records which of the two oscillators in that cell runs faster. Because the bit depends only on which of the pair is faster, a drift that speeds up or slows down both oscillators of a pair leaves the bit alone.

A single shared pair of edge counters serves all the cells in turn. A multiplexer routes one pair of oscillators to the counters, and each oscillator passes through a two-flop synchronizer and a rising-edge detector. The counters are cleared while the synchronizers settle. Both counters then count together for a gate window of N system-clock cycles. The comparison result is shifted into the key register, and the block moves on to the next cell.

The consumer pulses `start`, waits for `key_valid`, uses the key, and then pulses `clear` so that the key does not stay in storage between uses. A sticky flag marks cells whose two counts came out equal.

Top module: `ro_puf_keygen`

## Requirements
- R1: After a synchronous reset, `key` is zero and `key_valid`, `busy` and `tie_flag` are all low.
- R2: Cell i uses `osc_a[i]` as its first oscillator and `osc_b[i]` as its second. Its bit is 1 when the second oscillator counted more rising edges than the first during the gate window, and 0 otherwise.
- R3: Cells are evaluated in order from 0 to 63. The bit of cell i ends up at `key[i]`.
- R4: When the two counts of a cell are equal, that cell's bit is 0 and `tie_flag` goes high. `tie_flag` stays high until the next accepted start, a clear or a reset.
- R5: Scaling the periods of every oscillator by the same factor leaves the key unchanged.
- R6: A start pulse while idle raises `busy` from the next cycle. `key_valid` rises and `busy` falls exactly 64*(N+4) cycles after the edge that sampled the start. N is `gate_len` as sampled at the start, and a value of 0 selects 1024.
- R7: A start pulse while busy is ignored. Generation continues, with unchanged timing and result.
- R8: One cycle after a `clear` pulse, `key` is zero and `key_valid`, `busy` and `tie_flag` are all low. A generation in progress is aborted and produces no result.
- R9: `key` reads as zero whenever `key_valid` is low, including during generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new key; accepted only while idle |
| clear | input | 1 | Wipe the key, or abort a generation in progress |
| gate_len | input | 16 | Gate window in clock cycles; 0 selects 1024 |
| osc_a | input | 64 | First oscillator of each cell |
| osc_b | input | 64 | Second oscillator of each cell |
| key | output | 64 | Assembled key; zero unless valid |
| key_valid | output | 1 | Key complete and readable |
| busy | output | 1 | Generation in progress |
| tie_flag | output | 1 | Sticky flag: some cell had equal counts |

## Verification
The driver counts the clock edges between the edge that samples a start and the first falling clock edge at which `key_valid` is seen high. It compares that count with 64*(N+4): 64 cells, each taking 3 settle cycles, N gate cycles and one decide cycle. The assembled key and the tie flag are compared half a cycle after `key_valid` rises. The `busy` response is due one cycle after the start, and the wiped outputs are due one cycle after a clear. Every sample is taken on the falling clock edge, so each registered result has settled before it is read.

// File: rtl/puf_pkg.sv
`timescale 1ns/1ps
package puf_pkg;
    localparam int GATE_W       = 16;
    localparam int GATE_DEFAULT = 1024;
    localparam int SETTLE_CYC   = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_GATE,
        ST_DECIDE
    } puf_state_e;

    typedef struct packed {
        logic bit_val;
        logic tie;
    } cell_verdict_t;

    function automatic logic [GATE_W-1:0] effective_gate(input logic [GATE_W-1:0] req);
        return (req == '0) ? GATE_W'(GATE_DEFAULT) : req;
    endfunction
endpackage

// File: rtl/puf_sync_edge.sv
`timescale 1ns/1ps
module puf_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_out
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_out = sync_q & ~prev_q;
endmodule

// File: rtl/puf_edge_counter.sv
`timescale 1ns/1ps
module puf_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (en && inc && (count != '1))
            count <= count + 1'b1;
    end

    // R2: a cleared counter starts its window from zero
    assert_clr_zero_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));
endmodule

// File: rtl/puf_key_shift.sv
`timescale 1ns/1ps
module puf_key_shift
    import puf_pkg::*;
#(
    parameter int KEY_BITS = 64,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wipe,
    input  logic                begin_gen,
    input  logic                decide,
    input  logic [CNT_W-1:0]    cnt_a,
    input  logic [CNT_W-1:0]    cnt_b,
    output logic [KEY_BITS-1:0] key_q,
    output logic                tie_q
);
    cell_verdict_t verdict;

    always_comb begin
        verdict.bit_val = (cnt_b > cnt_a);
        verdict.tie     = (cnt_b == cnt_a);
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            key_q <= '0;
            tie_q <= 1'b0;
        end else if (begin_gen) begin
            key_q <= '0;
            tie_q <= 1'b0;
        end else if (decide) begin
            key_q <= {verdict.bit_val, key_q[KEY_BITS-1:1]};
            tie_q <= tie_q | verdict.tie;
        end
    end

    // R4: equal counts shift in a zero and raise the tie flag
    assert_tie_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (decide && !wipe && (cnt_a == cnt_b)) |=> (!key_q[KEY_BITS-1] && tie_q));

    // R2: a faster second oscillator shifts in a one
    assert_faster_one_R2: assert property (@(posedge clk) disable iff (rst)
        (decide && !wipe && (cnt_b > cnt_a)) |=> key_q[KEY_BITS-1]);
endmodule

// File: rtl/ro_puf_keygen.sv
`timescale 1ns/1ps
module ro_puf_keygen
    import puf_pkg::*;
#(
    parameter int KEY_BITS = 64,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                clear,
    input  logic [GATE_W-1:0]   gate_len,
    input  logic [KEY_BITS-1:0] osc_a,
    input  logic [KEY_BITS-1:0] osc_b,
    output logic [KEY_BITS-1:0] key,
    output logic                key_valid,
    output logic                busy,
    output logic                tie_flag
);
    localparam int IDX_W = $clog2(KEY_BITS);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);

    puf_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [GATE_W-1:0] timer, gate_q;
    logic [SET_W-1:0]  settle_cnt;
    logic              valid_q;

    logic [1:0]        mux_bit, rise;
    logic [CNT_W-1:0]  cnt [2];
    logic              cnt_clr, cnt_en, begin_gen, decide;
    logic [KEY_BITS-1:0] key_q;

    assign mux_bit[0] = osc_a[idx];
    assign mux_bit[1] = osc_b[idx];
    assign cnt_clr    = (state == ST_SETTLE);
    assign cnt_en     = (state == ST_GATE);
    assign begin_gen  = (state == ST_IDLE) && start && !clear;
    assign decide     = (state == ST_DECIDE);

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        puf_sync_edge u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (mux_bit[ch]),
            .rise_out (rise[ch])
        );
        puf_edge_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (cnt_clr),
            .en    (cnt_en),
            .inc   (rise[ch]),
            .count (cnt[ch])
        );
    end

    puf_key_shift #(.KEY_BITS(KEY_BITS), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .wipe      (clear),
        .begin_gen (begin_gen),
        .decide    (decide),
        .cnt_a     (cnt[0]),
        .cnt_b     (cnt[1]),
        .key_q     (key_q),
        .tie_q     (tie_flag)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state      <= ST_IDLE;
            idx        <= '0;
            timer      <= '0;
            gate_q     <= '0;
            settle_cnt <= '0;
            valid_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_SETTLE;
                    idx        <= '0;
                    settle_cnt <= '0;
                    gate_q     <= effective_gate(gate_len);
                    valid_q    <= 1'b0;
                end
                ST_SETTLE: begin
                    if (settle_cnt == SET_W'(SETTLE_CYC - 1)) begin
                        state <= ST_GATE;
                        timer <= '0;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_GATE: begin
                    if (timer == gate_q - GATE_W'(1))
                        state <= ST_DECIDE;
                    else
                        timer <= timer + 1'b1;
                end
                ST_DECIDE: begin
                    if (idx == IDX_W'(KEY_BITS - 1)) begin
                        state   <= ST_IDLE;
                        valid_q <= 1'b1;
                    end else begin
                        idx        <= idx + 1'b1;
                        settle_cnt <= '0;
                        state      <= ST_SETTLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign key_valid = valid_q;
    assign key       = valid_q ? key_q : '0;

    // R6: an accepted start makes the block busy on the next cycle
    assert_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
        begin_gen |=> busy);

    // R6: a valid key is never reported while still generating
    assert_valid_idle_R6: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> !busy);

    // R7: start during a gate or settle phase moves neither state nor cell
    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !clear && (state == ST_SETTLE || state == ST_GATE)) |=> (busy && $stable(idx)));

    // R8: clear wipes every output within one cycle
    assert_clear_wipe_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!key_valid && (key == '0) && !busy && !tie_flag));

    // R3: the key completes only after the last cell has been decided
    assert_valid_last_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(key_valid) |-> $past(decide && (idx == IDX_W'(KEY_BITS - 1))));
endmodule

// File: tb/ro_puf_keygen_bench.sv
`timescale 1ns/1ps
module ro_puf_keygen_bench;
    localparam int KB = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          clear = 1'b0;
    logic [15:0]   gate_len = '0;
    logic [KB-1:0] osc_a, osc_b;
    logic [KB-1:0] key;
    logic          key_valid, busy, tie_flag;
    logic [KB-1:0] tie_mask = '0;

    real ha [KB];
    real hb [KB];

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [KB-1:0] key;
        logic          tie;
        string         tag;
    } exp_item_t;
    exp_item_t sb_q [$];

    always #4 clk = ~clk;

    for (genvar i = 0; i < KB; i++) begin : g_osc
        logic ra = 1'b0;
        logic rb = 1'b0;
        always begin
            #(ha[i] > 1.0 ? ha[i] : 10.0);
            ra = ~ra;
        end
        always begin
            #(hb[i] > 1.0 ? hb[i] : 10.0);
            rb = ~rb;
        end
        assign osc_a[i] = ra;
        assign osc_b[i] = tie_mask[i] ? ra : rb;
    end

    ro_puf_keygen u_ro_puf_keygen (
        .clk(clk), .rst(rst), .start(start), .clear(clear), .gate_len(gate_len),
        .osc_a(osc_a), .osc_b(osc_b), .key(key), .key_valid(key_valid),
        .busy(busy), .tie_flag(tie_flag)
    );

    task automatic check(input bit ok, input string tag, input logic [KB-1:0] act, input logic [KB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic print_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // first oscillator faster for a 0 bit, second faster for a 1 bit
    task automatic set_pattern(input logic [KB-1:0] pat, input real scale);
        for (int i = 0; i < KB; i++) begin
            real base, slow;
            base = 20.0 + 2.0 * (i % 5);
            slow = base * 1.3;
            ha[i] = (pat[i] ? slow : base) * scale / 2.0;
            hb[i] = (pat[i] ? base : slow) * scale / 2.0;
        end
    endtask

    task automatic run_key(input logic [KB-1:0] exp_key, input logic exp_tie,
                           input logic [15:0] gate, input int exp_lat,
                           input bit inject, input string tag);
        int cycles;
        exp_item_t it;
        it.key = exp_key;
        it.tie = exp_tie;
        it.tag = tag;
        sb_q.push_back(it);
        gate_len = gate;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cycles = 0;
        check(busy == 1'b1, "R6 busy after start", {63'b0, busy}, 64'd1);
        while (!key_valid) begin
            @(negedge clk);
            cycles++;
            start = (inject && cycles == 500);
            if (cycles == 600)
                check(key == '0 && busy, "R9 key hidden while busy", key, '0);
        end
        start = 1'b0;
        check(cycles == exp_lat, {"R6 latency ", tag}, KB'(cycles), KB'(exp_lat));
    endtask

    initial begin : monitor
        exp_item_t it;
        forever begin
            @(posedge key_valid);
            @(negedge clk);
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected key_valid", key, '0);
            end else begin
                it = sb_q.pop_front();
                check(key == it.key, {"R2/R3 key ", it.tag}, key, it.key);
                check(tie_flag == it.tie, {"R4 tie ", it.tag}, {63'b0, tie_flag}, {63'b0, it.tie});
            end
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL R6 watchdog: actual=timeout expected=done");
        print_summary();
        $finish;
    end

    initial begin : main
        logic [KB-1:0] pat_a, pat_b, exp_b;
        pat_a = 64'hA5C3_0F96_3C5A_E71B;
        pat_b = 64'h5A3C_F069_C3A5_18E4;
        set_pattern(pat_a, 1.0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(key == '0 && !key_valid && !busy && !tie_flag, "R1 reset state",
              key, '0);

        // default window via gate_len 0, pattern A
        run_key(pat_a, 1'b0, 16'd0, 64 * (1024 + 4), 1'b0, "R2 pattern A default gate");
        @(negedge clk);

        // R5: every period scaled by 1.5, same key expected
        set_pattern(pat_a, 1.5);
        run_key(pat_a, 1'b0, 16'd256, 64 * (256 + 4), 1'b0, "R5 scaled periods");
        @(negedge clk);

        // pattern B, cell 5 tied, stray start while busy (R7)
        set_pattern(pat_b, 1.0);
        tie_mask = 64'h20;
        exp_b = pat_b & ~64'h20;
        run_key(exp_b, 1'b1, 16'd256, 64 * (256 + 4), 1'b1, "R7 R4 pattern B tie on cell 5");
        @(negedge clk);

        // R8: clear after use wipes the key
        clear = 1'b1;
        @(negedge clk) clear = 1'b0;
        check(key == '0 && !key_valid && !tie_flag && !busy, "R8 clear after valid", key, '0);

        // R8: clear aborts a generation in progress
        tie_mask = '0;
        gate_len = 16'd256;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (2000) @(negedge clk);
        clear = 1'b1;
        @(negedge clk) clear = 1'b0;
        check(!busy && !key_valid && key == '0, "R8 abort in progress", {62'b0, busy, key_valid}, '0);
        repeat (20000) @(negedge clk);
        check(!key_valid && !busy, "R8 aborted run yields nothing", {62'b0, busy, key_valid}, '0);

        // R4: tie flag cleared by a new start, short window
        run_key(pat_b, 1'b0, 16'd64, 64 * (64 + 4), 1'b0, "R4 pattern B no tie short gate");
        repeat (4) @(negedge clk);

        print_summary();
        $finish;
    end
endmodule